// File: doc/BRIEF.md
# Baud Tuning Meter

This block measures how long a serial receive line stays low after its first falling edge. Software uses the result to set its local baud generator to the remote transmitter's rate. The receive input is asynchronous. It first passes through a two-stage synchronizer. The block then waits for a high-to-low transition. From that point it counts sampling clocks until the line returns high, and it latches the count into a result register.

A completed capture does three things: it sets a valid flag, it raises a pending interrupt that software can mask, and it parks the block. While parked, the block ignores the line until software pulses an acknowledge. Dropping the enable at any moment abandons the measurement, but the last latched result is kept. The counter stops at its maximum value instead of wrapping, and a flag records that the stored width reached that limit.

Top module: `baud_tune_meter`

## Requirements
- R1: While reset is asserted, and right after it is released, `cuv_q` is 0 and `cuv_valid`, `cuv_sat` and `irq` are all 0.
- R2: `rx_in` is sampled through two flops before edge detection. `cuv_valid` becomes 1 after the third rising clock edge that samples `rx_in` high at the end of a low pulse, and not earlier.
- R3: The value latched into `cuv_q` equals the number of rising clock edges that sampled `rx_in` low during the pulse, including a pulse one clock long.
- R4: No measurement starts while `tune_en` is 0. A falling edge seen while disabled is ignored. A line that is already low when `tune_en` rises does not start a measurement.
- R5: After a capture the block holds `cuv_q` and `cuv_valid`, and ignores further pulses, until `ack` is pulsed.
- R6: `irq` is 1 exactly when `cuv_valid` is 1 and `irq_en` is 1. `cuv_valid` is still set by a capture while `irq_en` is 0.
- R7: The count stops at 65535 (2^CNT_W-1). A capture at that value sets `cuv_sat` to 1. The next capture below the limit clears it.
- R8: A one-cycle `ack` in the captured state clears `cuv_valid` and `irq` and rearms the edge search. `ack` in any other state has no effect.
- R9: `tune_en` = 0 clears `cuv_valid`, `irq` and the running count on the next edge. `cuv_q` and `cuv_sat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tune_en | input | 1 | Enables measurement; 0 aborts and idles |
| irq_en | input | 1 | Interrupt mask, 1 lets the pending flag reach `irq` |
| ack | input | 1 | One-cycle acknowledge; clears the result flags and rearms |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| cuv_q | output | CNT_W | Latched low-pulse width in sampling clocks |
| cuv_valid | output | 1 | A new width is held in `cuv_q` |
| cuv_sat | output | 1 | The stored width reached the counter limit |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions take for granted that `tune_en` and `irq_en` are level controls and that `ack` is a single-cycle strobe. They do not depend on how `rx_in` moves, because every path from `rx_in` goes through the synchronizer first. The stimulus changes every input only on the falling clock edge, so each value is stable well before the next sampling edge. Pulse lengths are stated in whole sampled clocks, which keeps the expected width exact. One long pulse drives the counter into saturation. The other pulses cover the single-clock boundary and aborts that land in the middle of a measurement.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_MEAS = 2'd1,
    BT_DONE = 2'd2
  } bt_state_e;
endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               line_now;
  logic               line_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[CHAIN_W-2:0], rx_in};
  end

  assign line_now  = chain_q[STAGES-1];
  assign line_prev = chain_q[STAGES];
  assign fall_evt  = line_prev & ~line_now;
  assign rise_evt  = ~line_prev & line_now;
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_one,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (load_one) cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (step)     cnt_q <= sat_inc(cnt_q);
  end

  assign at_max = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tune_en,
  input  logic             ack,
  input  logic             fall_evt,
  input  logic             rise_evt,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             at_max,
  output logic             cnt_clr,
  output logic             cnt_load,
  output logic             cnt_step,
  output logic             cap_evt,
  output logic             meas_q,
  output logic [CNT_W-1:0] cuv_q,
  output logic             cuv_valid,
  output logic             cuv_sat
);
  bt_state_e st_q, st_d;
  logic      ack_evt;

  assign ack_evt  = tune_en && (st_q == BT_DONE) && ack;
  assign cnt_clr  = !tune_en;
  assign cnt_load = tune_en && (st_q == BT_IDLE) && fall_evt;
  assign cnt_step = tune_en && (st_q == BT_MEAS) && !rise_evt;
  assign cap_evt  = tune_en && (st_q == BT_MEAS) && rise_evt;
  assign meas_q   = (st_q == BT_MEAS);

  always_comb begin
    st_d = st_q;
    if (!tune_en) st_d = BT_IDLE;
    else begin
      case (st_q)
        BT_IDLE: if (fall_evt) st_d = BT_MEAS;
        BT_MEAS: if (rise_evt) st_d = BT_DONE;
        BT_DONE: if (ack)      st_d = BT_IDLE;
        default:               st_d = BT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BT_IDLE;
      cuv_q     <= '0;
      cuv_valid <= 1'b0;
      cuv_sat   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_evt) begin
        cuv_q   <= cnt_q;
        cuv_sat <= at_max;
      end
      if (!tune_en)     cuv_valid <= 1'b0;
      else if (cap_evt) cuv_valid <= 1'b1;
      else if (ack_evt) cuv_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tune_meter.sv
module baud_tune_meter #(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tune_en,
  input  logic             irq_en,
  input  logic             ack,
  input  logic             rx_in,
  output logic [CNT_W-1:0] cuv_q,
  output logic             cuv_valid,
  output logic             cuv_sat,
  output logic             irq
);
  logic             fall_evt;
  logic             rise_evt;
  logic             cnt_clr;
  logic             cnt_load;
  logic             cnt_step;
  logic             cap_evt;
  logic             meas_q;
  logic             at_max;
  logic [CNT_W-1:0] cnt_q;

  bt_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_in    (rx_in),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .load_one (cnt_load),
    .step     (cnt_step),
    .cnt_q    (cnt_q),
    .at_max   (at_max)
  );

  bt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_en   (tune_en),
    .ack       (ack),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .cnt_q     (cnt_q),
    .at_max    (at_max),
    .cnt_clr   (cnt_clr),
    .cnt_load  (cnt_load),
    .cnt_step  (cnt_step),
    .cap_evt   (cap_evt),
    .meas_q    (meas_q),
    .cuv_q     (cuv_q),
    .cuv_valid (cuv_valid),
    .cuv_sat   (cuv_sat)
  );

  assign irq = cuv_valid & irq_en;
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tune_en,
  input logic             irq_en,
  input logic             ack,
  input logic [CNT_W-1:0] cuv_q,
  input logic             cuv_valid,
  input logic             cuv_sat,
  input logic             irq,
  input logic             rise_evt,
  input logic             cap_evt,
  input logic             meas_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && cuv_valid)); // R6

  AST_CAP_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cuv_valid); // R3

  AST_VALID_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cuv_valid) |-> $past(rise_evt)); // R2

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cuv_valid && !ack && tune_en) |=> (cuv_valid && $stable(cuv_q))); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_en |=> (!cuv_valid && $stable(cuv_q) && $stable(cuv_sat))); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_q && tune_en && !rise_evt && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7

  AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cuv_sat |-> (cuv_q == CNT_MAX)); // R7
endmodule

bind baud_tune_meter bt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tune_en   (tune_en),
  .irq_en    (irq_en),
  .ack       (ack),
  .cuv_q     (cuv_q),
  .cuv_valid (cuv_valid),
  .cuv_sat   (cuv_sat),
  .irq       (irq),
  .rise_evt  (rise_evt),
  .cap_evt   (cap_evt),
  .meas_q    (meas_q),
  .cnt_q     (cnt_q)
);

// File: tb/sim_baud_tune_meter.sv
`timescale 1ns/1ps
module sim_baud_tune_meter;
  localparam int LIM = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tune_en = 1'b0;
  logic        irq_en = 1'b0;
  logic        ack = 1'b0;
  logic        rx_in = 1'b1;
  logic [15:0] cuv_q;
  logic        cuv_valid, cuv_sat, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baud_tune_meter u0 (
    .clk(clk), .rst_n(rst_n), .tune_en(tune_en), .irq_en(irq_en), .ack(ack),
    .rx_in(rx_in), .cuv_q(cuv_q), .cuv_valid(cuv_valid), .cuv_sat(cuv_sat), .irq(irq)
  );

  // behavioural reference: history of sampled line, phase, width
  bit q_hist[$] = '{1'b1, 1'b1, 1'b1};
  int m_phase = 0;   // 0 waiting, 1 counting, 2 holding
  int m_width = 0;
  int m_cuv = 0;
  bit m_valid = 0;
  bit m_sat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_hist = '{1'b1, 1'b1, 1'b1};
      m_phase = 0; m_width = 0; m_cuv = 0; m_valid = 0; m_sat = 0;
    end else begin
      bit seen_now, seen_old;
      seen_now = q_hist[q_hist.size()-2];
      seen_old = q_hist[q_hist.size()-3];
      if (!tune_en) begin
        m_phase = 0; m_width = 0; m_valid = 0;
      end else if (m_phase == 0) begin
        if (seen_old && !seen_now) begin m_phase = 1; m_width = 1; end
      end else if (m_phase == 1) begin
        if (!seen_old && seen_now) begin
          m_cuv = m_width; m_sat = (m_width == LIM); m_valid = 1; m_phase = 2;
        end else if (m_width < LIM) m_width++;
      end else if (ack) begin
        m_phase = 0; m_valid = 0;
      end
      q_hist.push_back(rx_in);
      if (q_hist.size() > 4) void'(q_hist.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R3 model cuv", int'(cuv_q), m_cuv);
      check("R5 model valid", int'(cuv_valid), int'(m_valid));
      check("R7 model sat", int'(cuv_sat), int'(m_sat));
      check("R6 model irq", int'(irq), int'(m_valid && irq_en));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // low for n sampling edges, then high and wait until capture would be done
  task automatic pulse(int n);
    rx_in = 1'b0;
    step(n);
    rx_in = 1'b1;
    step(4);
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    step(1);
  endtask

  initial begin
    step(1);
    check("R1 reset cuv", int'(cuv_q), 0);
    check("R1 reset valid", int'(cuv_valid), 0);
    check("R1 reset sat", int'(cuv_sat), 0);
    check("R1 reset irq", int'(irq), 0);
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R1 after release valid", int'(cuv_valid), 0);

    tune_en = 1'b1; irq_en = 1'b1;
    step(2);
    // R2: timing of capture after the line returns high
    rx_in = 1'b0;
    step(10);
    rx_in = 1'b1;
    step(2);
    check("R2 not yet valid", int'(cuv_valid), 0);
    step(1);
    check("R2 valid on third edge", int'(cuv_valid), 1);
    check("R3 width 10", int'(cuv_q), 10);
    check("R6 irq raised", int'(irq), 1);

    pulse(5);
    check("R5 held width", int'(cuv_q), 10);
    check("R5 still valid", int'(cuv_valid), 1);

    ack_pulse();
    check("R8 ack clears valid", int'(cuv_valid), 0);
    check("R8 ack clears irq", int'(irq), 0);
    ack_pulse();
    check("R8 idle ack no effect", int'(cuv_q), 10);
    pulse(7);
    check("R8 rearmed width 7", int'(cuv_q), 7);
    ack_pulse();

    pulse(1);
    check("R3 single clock pulse", int'(cuv_q), 1);
    ack_pulse();

    irq_en = 1'b0;
    pulse(4);
    check("R6 valid while masked", int'(cuv_valid), 1);
    check("R6 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    step(1);
    check("R6 irq after unmask", int'(irq), 1);
    ack_pulse();

    tune_en = 1'b0;
    step(2);
    pulse(6);
    check("R4 disabled no capture", int'(cuv_valid), 0);
    check("R4 disabled width kept", int'(cuv_q), 4);

    rx_in = 1'b0;
    step(5);
    tune_en = 1'b1;
    step(3);
    rx_in = 1'b1;
    step(5);
    check("R4 enable while low", int'(cuv_valid), 0);

    rx_in = 1'b0;
    step(5);
    tune_en = 1'b0;
    step(1);
    rx_in = 1'b1;
    step(4);
    check("R9 abort no capture", int'(cuv_valid), 0);
    check("R9 abort keeps width", int'(cuv_q), 4);
    tune_en = 1'b1;
    step(2);

    pulse(3);
    check("R9 capture before drop", int'(cuv_q), 3);
    tune_en = 1'b0;
    step(2);
    check("R9 drop clears valid", int'(cuv_valid), 0);
    check("R9 drop clears irq", int'(irq), 0);
    check("R9 drop keeps width", int'(cuv_q), 3);
    tune_en = 1'b1;
    step(2);

    pulse(70000);
    check("R7 saturated width", int'(cuv_q), LIM);
    check("R7 saturation flag", int'(cuv_sat), 1);
    ack_pulse();
    pulse(2);
    check("R7 flag cleared", int'(cuv_sat), 0);
    check("R3 width 2", int'(cuv_q), 2);

    done = 1;
    step(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule